// File: doc/BRIEF.md
# Watchdog Fail-Count Reset Supervisor

This block decides when repeated bad watchdog servicing should force a system reset. Window violations, wrong answers and timeouts are decoded upstream. Each of them reaches the block as a single-cycle bad-event pulse, and each correct service arrives as a good-event pulse. The block keeps a saturating fail counter that software can read. When the device enters its active state, the counter is preset close to the limit. A reset request goes to the device state controller only when the counter is already full, a further bad event arrives, and the software reset-enable bit is set.

The block also keeps an answer-position counter that software reads to align its answer sequence. It reads 3 at the start of every sequence. The block stores no answer data. Software sees only the counters and a sticky fail flag.

Two resets are used. `rst_ni` is the device reset and clears the counters and flags. `por_ni` is the power-down reset and is the only reset that clears the reset-enable bit.

Top module: `wd_fail_supervisor`

## Requirements
- R1: In the cycle after `act_entry_i` is high, `fail_cnt_o` reads 5 and `ans_pos_o` reads 3. This load overrides any good, bad or answer event in the same cycle, and no reset request results from that cycle.
- R2: A bad event (`bad_evt_i`) raises `fail_cnt_o` by one, saturating at 7. A good event (`good_evt_i`) lowers it by one, saturating at 0. When both arrive in the same cycle, the bad event wins. Each change is visible in the next cycle.
- R3: A bad event while `fail_cnt_o` is 7 and `rst_en_o` is 1 makes `rst_req_o` high for exactly the next cycle.
- R4: While `rst_en_o` is 0, `rst_req_o` stays 0, and the counter keeps counting as in R2.
- R5: A cycle with `rst_en_we_i` high loads `rst_en_wdata_i` into `rst_en_o` for the next cycle. `rst_ni` leaves `rst_en_o` unchanged. Only `por_ni` low clears it.
- R6: Each `ans_acc_i` pulse lowers `ans_pos_o` by one. An accepted answer at 0 wraps the counter back to 3.
- R7: `fail_flag_o` is set in the cycle after a bad event that actually increments the counter. A cycle with `fail_clr_i` high clears it. If a set and a clear arrive in the same cycle, the set wins.
- R8: After reset, `fail_cnt_o` is 0, `ans_pos_o` is 3, `fail_flag_o` is 0 and `rst_req_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Device reset, active low, asynchronous |
| por_ni | input | 1 | Power-down reset, active low, asynchronous; clears reset enable |
| act_entry_i | input | 1 | Pulse on the change from diagnostic to active state |
| good_evt_i | input | 1 | Correct watchdog service pulse |
| bad_evt_i | input | 1 | Bad trigger, wrong answer or timeout pulse |
| ans_acc_i | input | 1 | Answer byte accepted pulse |
| fail_clr_i | input | 1 | Write-one-to-clear of the fail flag |
| rst_en_we_i | input | 1 | Reset-enable write strobe |
| rst_en_wdata_i | input | 1 | Reset-enable write data |
| fail_cnt_o | output | 3 | Fail counter |
| ans_pos_o | output | 2 | Answer-position counter |
| fail_flag_o | output | 1 | Sticky fail status |
| rst_en_o | output | 1 | Current reset-enable bit |
| rst_req_o | output | 1 | Reset request to the state controller |

## Verification
Seeded random event streams mix good, bad and answer pulses at comparable rates, with occasional active-state entries and enable writes. These runs test saturation at both ends and the bad-over-good priority. They also check whether a reset request depends on the enable bit in force before the event. Directed runs cover a preset of 5 followed by three bad events, once with the enable set and once with it clear; this separates "counts but stays quiet" from "fires". A device reset is applied with the enable set, then a power-down reset, which shows that only the second clears the bit. Runs of answer pulses cover the wrap from 0 back to 3.

// File: rtl/wdfs_pkg.sv
package wdfs_pkg;
  localparam int unsigned CNT_W    = 3;
  localparam int unsigned POS_W    = 2;
  localparam int unsigned ACT_LOAD = 5;
endpackage

// File: rtl/wdfs_fail_cnt.sv
module wdfs_fail_cnt #(
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned ACT_LOAD = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             good_i,
  input  logic             bad_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             at_max_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] MAX_V  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(ACT_LOAD);

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             inc, dec;

  assign inc = !load_i && bad_i && (cnt_q != MAX_V);
  assign dec = !load_i && !bad_i && good_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= LOAD_V;
    end else if (inc) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (dec) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // set wins over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (inc)    flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign cnt_o    = cnt_q;
  assign at_max_o = (cnt_q == MAX_V);
  assign flag_o   = flag_q;

  AST_LOAD_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == LOAD_V); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_max_o && bad_i && !load_i) |=> at_max_o); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0 && !bad_i && !load_i) |=> cnt_o == '0); // R2
  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !bad_i) |=> !flag_o); // R7
endmodule

// File: rtl/wdfs_ans_pos.sv
module wdfs_ans_pos #(
  parameter int unsigned POS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             acc_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] TOP_V = {POS_W{1'b1}};

  logic [POS_W-1:0] pos_q;

  // natural wrap of the down counter returns 0 to TOP_V
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= TOP_V;
    else if (load_i) pos_q <= TOP_V;
    else if (acc_i)  pos_q <= pos_q - 1'b1;
  end

  assign pos_o = pos_q;

  AST_POS_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_o == '0 && acc_i && !load_i) |=> pos_o == TOP_V); // R6
  AST_POS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_i && !load_i) |=> $stable(pos_o)); // R6
endmodule

// File: rtl/wdfs_rst_gate.sv
module wdfs_rst_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic por_ni,
  input  logic en_we_i,
  input  logic en_wdata_i,
  input  logic load_i,
  input  logic bad_i,
  input  logic at_max_i,
  output logic en_o,
  output logic req_o
);
  logic en_q, req_q;

  // enable survives device reset; only power-down clears it
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)      en_q <= 1'b0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= en_q && bad_i && at_max_i && !load_i;
  end

  assign en_o  = en_q;
  assign req_o = req_q;

  AST_REQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (!en_o && !en_we_i) |=> !req_o); // R4
  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o || $past(bad_i)); // R3
  AST_EN_WRITE: assert property (@(posedge clk_i) disable iff (!por_ni)
    en_we_i |=> en_o == $past(en_wdata_i)); // R5
endmodule

// File: rtl/wd_fail_supervisor.sv
module wd_fail_supervisor
  import wdfs_pkg::*;
#(
  parameter int unsigned FAIL_W  = CNT_W,
  parameter int unsigned APOS_W  = POS_W,
  parameter int unsigned PRESET  = ACT_LOAD
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_ni,
  input  logic              act_entry_i,
  input  logic              good_evt_i,
  input  logic              bad_evt_i,
  input  logic              ans_acc_i,
  input  logic              fail_clr_i,
  input  logic              rst_en_we_i,
  input  logic              rst_en_wdata_i,
  output logic [FAIL_W-1:0] fail_cnt_o,
  output logic [APOS_W-1:0] ans_pos_o,
  output logic              fail_flag_o,
  output logic              rst_en_o,
  output logic              rst_req_o
);
  logic at_max;

  wdfs_fail_cnt #(.CNT_W(FAIL_W), .ACT_LOAD(PRESET)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (act_entry_i),
    .good_i   (good_evt_i),
    .bad_i    (bad_evt_i),
    .clr_i    (fail_clr_i),
    .cnt_o    (fail_cnt_o),
    .at_max_o (at_max),
    .flag_o   (fail_flag_o)
  );

  wdfs_ans_pos #(.POS_W(APOS_W)) u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (act_entry_i),
    .acc_i  (ans_acc_i),
    .pos_o  (ans_pos_o)
  );

  wdfs_rst_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_ni     (por_ni),
    .en_we_i    (rst_en_we_i),
    .en_wdata_i (rst_en_wdata_i),
    .load_i     (act_entry_i),
    .bad_i      (bad_evt_i),
    .at_max_i   (at_max),
    .en_o       (rst_en_o),
    .req_o      (rst_req_o)
  );
endmodule

// File: tb/wd_fail_supervisor_test.sv
`timescale 1ns/1ps
module wd_fail_supervisor_test;
  logic clk = 0, rst_ni = 0, por_ni = 0;
  logic act, good, bad, acc, clr, we, wd;
  logic [2:0] fail_cnt;
  logic [1:0] ans_pos;
  logic flag, en, req;

  int tests = 0, fails = 0;
  bit done = 0;
  // model state
  int m_cnt, m_pos;
  bit m_flag, m_en, m_req;

  always #2.5 clk = ~clk;

  wd_fail_supervisor uut (
    .clk_i(clk), .rst_ni(rst_ni), .por_ni(por_ni), .act_entry_i(act),
    .good_evt_i(good), .bad_evt_i(bad), .ans_acc_i(acc), .fail_clr_i(clr),
    .rst_en_we_i(we), .rst_en_wdata_i(wd), .fail_cnt_o(fail_cnt),
    .ans_pos_o(ans_pos), .fail_flag_o(flag), .rst_en_o(en), .rst_req_o(req)
  );

  function automatic int nxt_cnt(int c, bit l, bit g, bit b);
    if (l) return 5;
    if (b) return (c < 7) ? c + 1 : 7;
    if (g) return (c > 0) ? c - 1 : 0;
    return c;
  endfunction

  function automatic int nxt_pos(int p, bit l, bit a);
    if (l) return 3;
    if (a) return (p == 0) ? 3 : p - 1;
    return p;
  endfunction

  task automatic chk(string r, int act_v, int exp_v);
    tests++;
    if (act_v != exp_v) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act_v, exp_v, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 fail_cnt", fail_cnt, m_cnt);
    chk("R6 ans_pos", ans_pos, m_pos);
    chk("R7 fail_flag", flag, m_flag);
    chk("R5 rst_en", en, m_en);
    chk("R3 rst_req", req, m_req);
  endtask

  // called at a negedge: drive, advance model, compare at next negedge
  task automatic step(bit l, bit g, bit b, bit a, bit c, bit w, bit d);
    bit inc;
    act = l; good = g; bad = b; acc = a; clr = c; we = w; wd = d;
    inc    = !l && b && (m_cnt < 7);
    m_req  = m_en && b && (m_cnt == 7) && !l;
    m_flag = inc ? 1'b1 : (c ? 1'b0 : m_flag);
    m_cnt  = nxt_cnt(m_cnt, l, g, b);
    m_pos  = nxt_pos(m_pos, l, a);
    if (w) m_en = d;
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset(bit power);
    rst_ni = 0;
    if (power) por_ni = 0;
    {act, good, bad, acc, clr, we, wd} = '0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1; por_ni = 1;
    m_cnt = 0; m_pos = 3; m_flag = 0; m_req = 0;
    if (power) m_en = 0;
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0101));
    m_en = 0;
    @(negedge clk);
    do_reset(1);
    // R8 reset state
    chk("R8 cnt", fail_cnt, 0); chk("R8 pos", ans_pos, 3);
    chk("R8 flag", flag, 0);    chk("R8 req", req, 0);

    // R1 preset overrides a bad event in the same cycle
    step(1, 0, 1, 1, 0, 0, 0);
    chk("R1 preset", fail_cnt, 5); chk("R1 pos", ans_pos, 3);
    // R4 enable clear: 5->6->7->7, no request
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R4 counts", fail_cnt, 7); chk("R4 no req", req, 0);
    // R3 enable set then bad at 7
    step(0, 0, 0, 0, 0, 1, 1);
    step(0, 0, 1, 0, 0, 0, 0);
    chk("R3 req", req, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    chk("R3 single", req, 0);
    // R2 good and bad together at 7: stays 7
    step(0, 1, 1, 0, 0, 0, 0);
    chk("R2 bad wins", fail_cnt, 7);
    // R7 clear then set-wins
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R7 clear", flag, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 1, 0, 1, 0, 0);
    chk("R7 set wins", flag, 1);
    // R6 wrap 3->2->1->0->3
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1, 0, 0, 0);
    chk("R6 wrap", ans_pos, 3);
    // R5 device reset keeps enable, power-down clears it
    do_reset(0);
    chk("R5 kept", en, 1); chk("R8 cnt after rst", fail_cnt, 0);
    do_reset(1);
    chk("R5 cleared", en, 0);

    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      step(($urandom_range(0, 39) == 0), (r < 35), (r >= 60),
           $urandom_range(0, 1) == 1, ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 29) == 0), $urandom_range(0, 1) == 1);
      if (n == 2000) do_reset(0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule